// File: doc/BRIEF.md
# Dual-Bus Synchronous Cache SRAM

A clocked 9-bit-wide memory that sits between a processor-side bus and a system-side bus. The two buses share one address but each has its own 9-bit data port (8 data bits plus a parity bit, stored as-is). Each port has an active-low input enable, an active-low output enable, a data input register and an output latch. A single active-low write enable completes the control set.

On every rising clock edge the block registers the controls, the address and both ports' input data. In the next cycle it decodes the registered controls into a mode. The mode may be a read to one or both ports, an array write from either port, a write that also copies the incoming word to the other port, a port-to-port copy that leaves the array untouched, or a no-operation. The block then loads and enables the output latches. Tri-state control is exposed as a per-port drive-enable output next to the port's data output. Unsupported combinations raise a one-cycle flag and are treated as a safe no-operation.

The depth is `2**ADDR_W` words. The default of 10 keeps elaboration small. Setting `ADDR_W = 17` gives the full 128K-word array.

Top module: `dual_cache_sram`

## Requirements
- R1: The array holds `2**ADDR_W` words of 9 bits. A word written in one operation is returned unchanged by a later read of the same address, including a read issued in the very next cycle.
- R2: Controls, address and data are sampled on the rising edge k. The resulting port drive enables and data change on edge k+1, and not on edge k.
- R3: With we_ni=1, p_ie_ni=1 and s_ie_ni=1, the array word at the address goes to the processor port when p_oe_ni=0 and to the system port when s_oe_ni=0. Both ports receive it when both output enables are 0.
- R4: With we_ni=1, both input enables 1 and both output enables 1, neither port is driven, no array write happens and illegal_o stays 0.
- R5: A port whose input enable is sampled 0 is never driven in the resulting cycle, whatever its output enable.
- R6: With we_ni=0, p_ie_ni=0, s_ie_ni=1 and p_oe_ni=1, the processor word is written to the array. If s_oe_ni=0, the same word is also driven on the system port; otherwise that port is not driven.
- R7: With we_ni=0, s_ie_ni=0, p_ie_ni=1 and s_oe_ni=1, the system word is written to the array. If p_oe_ni=0, the same word is also driven on the processor port; otherwise that port is not driven.
- R8: With we_ni=1, p_ie_ni=0, s_ie_ni=1, p_oe_ni=1 and s_oe_ni=0, the processor word is driven on the system port. With we_ni=1, s_ie_ni=0, p_ie_ni=1, s_oe_ni=1 and p_oe_ni=0, the system word is driven on the processor port. Neither case writes the array.
- R9: Both input enables at 0 (any we_ni), or we_ni=0 with both input enables at 1, drives neither port, leaves the array unchanged and keeps illegal_o at 0.
- R10: illegal_o is 1 for the cycle that follows the sample of any unsupported combination. Such a combination is a port's input enable at 0 with its own output enable at 0 while the other input enable is 1. It is also we_ni=1 with exactly one input enable at 0 and both output enables at 1. In that cycle both ports are not driven and the array is unchanged.
- R11: While rst_ni is 0 and in the first cycle after, p_oe_o, s_oe_o and illegal_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Shared word address |
| we_ni | input | 1 | Write enable, active low |
| p_ie_ni | input | 1 | Processor port input enable, active low |
| s_ie_ni | input | 1 | System port input enable, active low |
| p_oe_ni | input | 1 | Processor port output enable, active low |
| s_oe_ni | input | 1 | System port output enable, active low |
| p_d_i | input | DW | Processor port data into the block |
| s_d_i | input | DW | System port data into the block |
| p_d_o | output | DW | Processor port output latch |
| p_oe_o | output | 1 | Processor port drive enable (0 = high-Z) |
| s_d_o | output | DW | System port output latch |
| s_oe_o | output | 1 | System port drive enable (0 = high-Z) |
| illegal_o | output | 1 | One-cycle flag for an unsupported control combination |

## Verification
The checker assumes that inputs are stable around each rising edge. It relates them to outputs exactly two sampled edges later, so it assumes the inputs sampled at the first edge after reset release are already meaningful. The bench keeps within this by driving every input on the falling edge and holding all enables inactive through reset. Data comparisons are made only while a port is driven, because the output latch keeps a stale word otherwise. For that reason the bench pre-fills every address it later reads, so the reference array never holds unknown words.

// File: rtl/dual_cache_sram_pkg.sv
package dual_cache_sram_pkg;

  typedef struct packed {
    logic we_n;
    logic p_ie_n;
    logic s_ie_n;
    logic p_oe_n;
    logic s_oe_n;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{we_n: 1'b1, p_ie_n: 1'b1, s_ie_n: 1'b1,
                                p_oe_n: 1'b1, s_oe_n: 1'b1};

  // index 0 = processor port, 1 = system port
  typedef struct packed {
    logic       wr;
    logic       wr_from_s;
    logic [1:0] ld_arr;
    logic [1:0] ld_peer;
    logic       illegal;
  } dec_t;

endpackage

// File: rtl/sram_ctl_dec.sv
module sram_ctl_dec
  import dual_cache_sram_pkg::*;
(
  input  ctl_t ctl_i,
  output dec_t dec_o
);

  always_comb begin
    dec_o = '0;
    if (!ctl_i.p_ie_n && !ctl_i.s_ie_n) begin
      dec_o = '0;                               // no array cycle
    end else if (ctl_i.p_ie_n && ctl_i.s_ie_n) begin
      if (ctl_i.we_n) begin
        dec_o.ld_arr[0] = !ctl_i.p_oe_n;
        dec_o.ld_arr[1] = !ctl_i.s_oe_n;
      end
    end else if (!ctl_i.p_ie_n) begin           // data enters processor port
      if (!ctl_i.p_oe_n) begin
        dec_o.illegal = 1'b1;
      end else if (!ctl_i.we_n) begin
        dec_o.wr         = 1'b1;
        dec_o.ld_peer[1] = !ctl_i.s_oe_n;
      end else if (!ctl_i.s_oe_n) begin
        dec_o.ld_peer[1] = 1'b1;
      end else begin
        dec_o.illegal = 1'b1;
      end
    end else begin                              // data enters system port
      if (!ctl_i.s_oe_n) begin
        dec_o.illegal = 1'b1;
      end else if (!ctl_i.we_n) begin
        dec_o.wr         = 1'b1;
        dec_o.wr_from_s  = 1'b1;
        dec_o.ld_peer[0] = !ctl_i.p_oe_n;
      end else if (!ctl_i.p_oe_n) begin
        dec_o.ld_peer[0] = 1'b1;
      end else begin
        dec_o.illegal = 1'b1;
      end
    end
  end

endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int ADDR_W = 10,
  parameter int DW     = 9
) (
  input  logic              clk_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];

endmodule

// File: rtl/sram_out_latch.sv
module sram_out_latch #(
  parameter int DW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_arr_i,
  input  logic          ld_peer_i,
  input  logic [DW-1:0] arr_i,
  input  logic [DW-1:0] peer_i,
  output logic [DW-1:0] q_o,
  output logic          oe_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o  <= '0;
      oe_o <= 1'b0;
    end else begin
      oe_o <= ld_arr_i | ld_peer_i;
      if (ld_arr_i)       q_o <= arr_i;
      else if (ld_peer_i) q_o <= peer_i;
    end
  end

endmodule

// File: rtl/dual_cache_sram.sv
module dual_cache_sram
  import dual_cache_sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DW     = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_ni,
  input  logic              p_ie_ni,
  input  logic              s_ie_ni,
  input  logic              p_oe_ni,
  input  logic              s_oe_ni,
  input  logic [DW-1:0]     p_d_i,
  input  logic [DW-1:0]     s_d_i,
  output logic [DW-1:0]     p_d_o,
  output logic              p_oe_o,
  output logic [DW-1:0]     s_d_o,
  output logic              s_oe_o,
  output logic              illegal_o
);

  localparam int NPORT = 2;

  ctl_t              ctl_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DW-1:0]     din_q [NPORT];
  logic [DW-1:0]     dout  [NPORT];
  logic              doe   [NPORT];
  dec_t              dec;
  logic [DW-1:0]     rdata;
  logic [DW-1:0]     wdata;

  // sample stage: control, address and per-port input registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q     <= CTL_IDLE;
      addr_q    <= '0;
      din_q[0]  <= '0;
      din_q[1]  <= '0;
    end else begin
      ctl_q     <= '{we_n: we_ni, p_ie_n: p_ie_ni, s_ie_n: s_ie_ni,
                     p_oe_n: p_oe_ni, s_oe_n: s_oe_ni};
      addr_q    <= addr_i;
      din_q[0]  <= p_d_i;
      din_q[1]  <= s_d_i;
    end
  end

  sram_ctl_dec u_dec (
    .ctl_i (ctl_q),
    .dec_o (dec)
  );

  assign wdata = dec.wr_from_s ? din_q[1] : din_q[0];

  sram_array #(.ADDR_W(ADDR_W), .DW(DW)) u_array (
    .clk_i   (clk_i),
    .wr_i    (dec.wr),
    .addr_i  (addr_q),
    .wdata_i (wdata),
    .rdata_o (rdata)
  );

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    sram_out_latch #(.DW(DW)) u_latch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ld_arr_i  (dec.ld_arr[g]),
      .ld_peer_i (dec.ld_peer[g]),
      .arr_i     (rdata),
      .peer_i    (din_q[NPORT-1-g]),
      .q_o       (dout[g]),
      .oe_o      (doe[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) illegal_o <= 1'b0;
    else         illegal_o <= dec.illegal;
  end

  assign p_d_o  = dout[0];
  assign p_oe_o = doe[0];
  assign s_d_o  = dout[1];
  assign s_oe_o = doe[1];

endmodule

// File: rtl/dual_cache_sram_chk.sv
module dual_cache_sram_chk #(
  parameter int ADDR_W = 10,
  parameter int DW     = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_ni,
  input logic              p_ie_ni,
  input logic              s_ie_ni,
  input logic              p_oe_ni,
  input logic              s_oe_ni,
  input logic [DW-1:0]     p_d_i,
  input logic [DW-1:0]     s_d_i,
  input logic [DW-1:0]     p_d_o,
  input logic              p_oe_o,
  input logic [DW-1:0]     s_d_o,
  input logic              s_oe_o,
  input logic              illegal_o
);

  logic [1:0] age_q;
  logic       warm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end
  assign warm = (age_q == 2'd2);

  p_reset_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd0) |-> (!p_oe_o && !s_oe_o && !illegal_o));

  p_p_ie_hiz_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(!p_ie_ni, 2)) |-> !p_oe_o);

  p_s_ie_hiz_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(!s_ie_ni, 2)) |-> !s_oe_o);

  p_nop_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(!p_ie_ni && !s_ie_ni, 2)) |-> (!p_oe_o && !s_oe_o && !illegal_o));

  p_write_through_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(!we_ni && !p_ie_ni && s_ie_ni && p_oe_ni && !s_oe_ni, 2))
      |-> (s_oe_o && s_d_o == $past(p_d_i, 2)));

  p_alloc_stream_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(!we_ni && !s_ie_ni && p_ie_ni && s_oe_ni && !p_oe_ni, 2))
      |-> (p_oe_o && p_d_o == $past(s_d_i, 2)));

  p_contention_flag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past((!p_ie_ni && !p_oe_ni && s_ie_ni) ||
                   (!s_ie_ni && !s_oe_ni && p_ie_ni), 2)) |-> illegal_o);

  p_illegal_hiz_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!p_oe_o && !s_oe_o));

endmodule

bind dual_cache_sram dual_cache_sram_chk #(.ADDR_W(ADDR_W), .DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .we_ni     (we_ni),
  .p_ie_ni   (p_ie_ni),
  .s_ie_ni   (s_ie_ni),
  .p_oe_ni   (p_oe_ni),
  .s_oe_ni   (s_oe_ni),
  .p_d_i     (p_d_i),
  .s_d_i     (s_d_i),
  .p_d_o     (p_d_o),
  .p_oe_o    (p_oe_o),
  .s_d_o     (s_d_o),
  .s_oe_o    (s_oe_o),
  .illegal_o (illegal_o)
);

// File: tb/sim_dual_cache_sram.sv
module sim_dual_cache_sram;

  localparam int ADDR_W = 10;
  localparam int DW     = 9;
  localparam int NFILL  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              we_n = 1'b1, pie_n = 1'b1, sie_n = 1'b1, poe_n = 1'b1, soe_n = 1'b1;
  logic [DW-1:0]     pd = '0, sd = '0;
  logic [DW-1:0]     p_q, s_q;
  logic              p_oe, s_oe, illegal;

  int checks = 0;
  int fails  = 0;
  logic [DW-1:0] ref_mem [NFILL];

  always #10 clk = ~clk;   // 50 MHz

  dual_cache_sram #(.ADDR_W(ADDR_W), .DW(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr),
    .we_ni(we_n), .p_ie_ni(pie_n), .s_ie_ni(sie_n), .p_oe_ni(poe_n), .s_oe_ni(soe_n),
    .p_d_i(pd), .s_d_i(sd),
    .p_d_o(p_q), .p_oe_o(p_oe), .s_d_o(s_q), .s_oe_o(s_oe), .illegal_o(illegal)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic set_idle();
    we_n = 1'b1; pie_n = 1'b1; sie_n = 1'b1; poe_n = 1'b1; soe_n = 1'b1;
  endtask

  // Run one operation, follow it with an idle cycle, compare after edge k+1.
  // ctl = {we_n, p_ie_n, s_ie_n, p_oe_n, s_oe_n}
  task automatic run_op(input logic [4:0] ctl, input int a,
                        input logic [DW-1:0] pv, input logic [DW-1:0] sv,
                        input string req);
    logic w, pi, si, po, so;
    logic e_pdrv, e_sdrv, e_ill;
    logic [DW-1:0] e_p, e_s;
    {w, pi, si, po, so} = ctl;
    e_pdrv = 0; e_sdrv = 0; e_ill = 0; e_p = '0; e_s = '0;
    if (!pi && !si) begin
    end else if (pi && si) begin
      if (w) begin
        e_pdrv = !po; e_sdrv = !so; e_p = ref_mem[a]; e_s = ref_mem[a];
      end
    end else if (!pi) begin
      if (!po) e_ill = 1;
      else if (!w) begin ref_mem[a] = pv; e_sdrv = !so; e_s = pv; end
      else if (!so) begin e_sdrv = 1; e_s = pv; end
      else e_ill = 1;
    end else begin
      if (!so) e_ill = 1;
      else if (!w) begin ref_mem[a] = sv; e_pdrv = !po; e_p = sv; end
      else if (!po) begin e_pdrv = 1; e_p = sv; end
      else e_ill = 1;
    end
    @(negedge clk);
    {we_n, pie_n, sie_n, poe_n, soe_n} = ctl;
    addr = ADDR_W'(a); pd = pv; sd = sv;
    @(negedge clk);
    set_idle();
    @(negedge clk);
    chk(illegal === e_ill, req, "illegal_o", 32'(illegal), 32'(e_ill));
    chk(p_oe === e_pdrv, req, "p_oe_o", 32'(p_oe), 32'(e_pdrv));
    chk(s_oe === e_sdrv, req, "s_oe_o", 32'(s_oe), 32'(e_sdrv));
    if (e_pdrv) chk(p_q === e_p, req, "p_d_o", 32'(p_q), 32'(e_p));
    if (e_sdrv) chk(s_q === e_s, req, "s_d_o", 32'(s_q), 32'(e_s));
  endtask

  task automatic dual_read(input int a, input string req);
    run_op(5'b11100, a, '0, '0, req);
  endtask

  task automatic t_reset();
    chk(!p_oe && !s_oe && !illegal, "R11", "quiet in reset",
        {29'b0, p_oe, s_oe, illegal}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(!p_oe && !s_oe && !illegal, "R11", "quiet after reset",
        {29'b0, p_oe, s_oe, illegal}, 32'h0);
  endtask

  task automatic t_fill();
    for (int i = 0; i < NFILL; i++) run_op(5'b00111, i, DW'(9'h40 + i), '0, "R6");
    for (int i = 0; i < NFILL; i++) dual_read(i, "R1");
  endtask

  task automatic t_latency();
    // write then back-to-back read of the same address, watch each edge
    @(negedge clk);
    {we_n, pie_n, sie_n, poe_n, soe_n} = 5'b00111; addr = 10'd3; pd = 9'h1A5;
    ref_mem[3] = 9'h1A5;
    @(negedge clk);
    {we_n, pie_n, sie_n, poe_n, soe_n} = 5'b11101;
    chk(!p_oe, "R2", "no drive after write edge", 32'(p_oe), 32'h0);
    @(negedge clk);
    set_idle();
    chk(!p_oe, "R2", "read not visible on its own edge", 32'(p_oe), 32'h0);
    @(negedge clk);
    chk(p_oe && p_q === 9'h1A5, "R1", "next-cycle read of written word",
        32'(p_q), 32'h1A5);
  endtask

  task automatic t_reads();
    run_op(5'b11101, 5, '0, '0, "R3");
    run_op(5'b11110, 6, '0, '0, "R3");
    run_op(5'b11100, 7, '0, '0, "R3");
    run_op(5'b11111, 7, 9'h1FF, 9'h1FF, "R4");
    dual_read(7, "R4");
  endtask

  task automatic t_ie_hiz();
    run_op(5'b10110, 8, 9'h055, '0, "R5");   // p IE low, s OE low: stream, p hi-Z
    run_op(5'b11001, 8, '0, 9'h0AA, "R5");   // s IE low, p OE low: stream, s hi-Z
    dual_read(8, "R5");
  endtask

  task automatic t_write_through();
    run_op(5'b00110, 9, 9'h133, '0, "R6");
    run_op(5'b00111, 10, 9'h0F0, '0, "R6");
    dual_read(9, "R6");
    dual_read(10, "R6");
  endtask

  task automatic t_allocate();
    run_op(5'b01011, 11, '0, 9'h1C3, "R7");
    run_op(5'b01001, 12, '0, 9'h03C, "R7");
    dual_read(11, "R7");
    dual_read(12, "R7");
  endtask

  task automatic t_inhibit();
    run_op(5'b10110, 13, 9'h111, '0, "R8");
    run_op(5'b11001, 13, '0, 9'h122, "R8");
    dual_read(13, "R8");
  endtask

  task automatic t_nop();
    run_op(5'b00000, 14, 9'h1EE, 9'h1DD, "R9");
    run_op(5'b10011, 14, 9'h1EE, 9'h1DD, "R9");
    run_op(5'b01111, 14, 9'h1EE, 9'h1DD, "R9");
    dual_read(14, "R9");
  endtask

  task automatic t_illegal();
    run_op(5'b00101, 15, 9'h177, '0, "R10");  // p IE+OE low with write
    run_op(5'b01010, 15, '0, 9'h166, "R10");  // s IE+OE low with write
    run_op(5'b10111, 15, 9'h155, '0, "R10");  // unlisted: p in, no OE
    run_op(5'b11011, 15, '0, 9'h144, "R10");  // unlisted: s in, no OE
    run_op(5'b10100, 15, 9'h133, '0, "R10");
    dual_read(15, "R10");
  endtask

  task automatic t_random();
    for (int n = 0; n < 300; n++) begin
      run_op(5'($urandom), int'($urandom_range(NFILL - 1)),
             DW'($urandom), DW'($urandom), "R10");
    end
    for (int i = 0; i < NFILL; i++) dual_read(i, "R1");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_fill();
    t_latency();
    t_reads();
    t_ie_hiz();
    t_write_through();
    t_allocate();
    t_inhibit();
    t_nop();
    t_illegal();
    t_random();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule